// File: doc/BRIEF.md
# Status and Destination Writeback Stage

This block is the last stage of a pipelined 8-bit processor core. Each processor cycle it receives the registered ALU result with the carry and overflow side outputs, and two control fields from earlier stages. A per-bit mask says which status bits may change. A destination code says which of the architectural registers takes the result. It derives the new flag values from the result itself. It merges them into the status register under the mask, and writes the result into the selected destination.

A processor cycle is modelled as two periods of one clock, marked by the phase input `half_i`. A clock edge taken while `half_i` is low is the mid-cycle commit edge, where status and destination writes take effect. A clock edge taken while `half_i` is high is the end-of-cycle sample edge. There the sampled status, a selected register and a branch decision are registered onto the outputs. Because the commit comes first, a read or branch test in the same processor cycle as a write already sees the written value.

Top module: `wbu_top`

## Requirements
- R1: While reset is asserted and right after it, `status_o` is 8'h24, `rd_data_o` is 0 and `br_taken_o` is 0. All destination registers hold 0.
- R2: At a commit edge, status bit 7 (N) takes result bit 7 and bit 1 (Z) is 1 exactly when the result is zero. Each applies only where its mask bit in `ftm_i` is 1.
- R3: At a commit edge, status bit 0 (C) takes `carry_i` and bit 6 (V) takes `ovf_i`, each only where its mask bit is 1.
- R4: Status bits whose `ftm_i` bit is 0 keep their value. Status bit 5 always reads 1.
- R5: At a commit edge, status bits 4, 3 and 2 take result bits 4, 3 and 2 where their mask bits are 1.
- R6: A destination code `rtm_i` of k in 1..NUM_DEST writes the result into register k at the commit edge. No other register changes.
- R7: A destination code of 0, or one above NUM_DEST, writes no register.
- R8: Inputs present at a sample edge (`half_i` high) change neither the status nor any register.
- R9: Outputs change only at sample edges. A read in the same processor cycle as a write returns the written value.
- R10: At a sample edge, `br_taken_o` becomes 1 exactly when status bit `br_sel_i` equals `br_want_i`, using the status after that cycle's commit.
- R11: At a sample edge, `rd_data_o` takes register `rd_sel_i` for 1..NUM_DEST, and 0 for any other select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per processor cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| half_i | input | 1 | Phase: 0 in first half (commit edge ends it), 1 in second half (sample edge ends it) |
| res_i | input | 8 | Registered ALU result |
| carry_i | input | 1 | ALU carry out |
| ovf_i | input | 1 | ALU signed overflow |
| ftm_i | input | 8 | Status bit update mask |
| rtm_i | input | 4 | Destination code, 0 = none |
| rd_sel_i | input | 4 | Register read select, 0 = none |
| br_sel_i | input | 3 | Status bit index tested by the branch |
| br_want_i | input | 1 | Value the tested bit must have |
| status_o | output | 8 | Status sampled at end of cycle |
| rd_data_o | output | 8 | Selected register sampled at end of cycle |
| br_taken_o | output | 1 | Branch decision sampled at end of cycle |

## Verification
The hardest case to reach is a status change and a branch test on the changed bit in the same processor cycle, together with control fields that change between the two phases. The directed stimulus drives a mask, result and branch select in the first half. It then swaps in a different destination, mask and result for the second half. The bench checks that the branch follows the first-half update and that the second-half values leave no trace. Register writes are read back in their own cycle and again later, so that a commit at the wrong edge or a stray write shows at the read port.

// File: rtl/wbu_pkg.sv
package wbu_pkg;
    localparam int DATA_W = 8;
    localparam int BIT_C  = 0;
    localparam int BIT_Z  = 1;
    localparam int BIT_I  = 2;
    localparam int BIT_D  = 3;
    localparam int BIT_B  = 4;
    localparam int BIT_1  = 5;
    localparam int BIT_V  = 6;
    localparam int BIT_N  = 7;
    localparam logic [DATA_W-1:0] STATUS_RST = 8'h24;
    localparam logic [DATA_W-1:0] STATUS_ONE = 8'h20;
endpackage

// File: rtl/wbu_flag_calc.sv
module wbu_flag_calc
    import wbu_pkg::*;
(
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output logic [DATA_W-1:0] flags_o
);
    always_comb begin
        flags_o        = '0;
        flags_o[BIT_N] = res_i[DATA_W-1];
        flags_o[BIT_V] = ovf_i;
        flags_o[BIT_1] = 1'b1;
        flags_o[BIT_B] = res_i[BIT_B];
        flags_o[BIT_D] = res_i[BIT_D];
        flags_o[BIT_I] = res_i[BIT_I];
        flags_o[BIT_Z] = (res_i == '0);
        flags_o[BIT_C] = carry_i;
    end
endmodule

// File: rtl/wbu_dest_decode.sv
module wbu_dest_decode #(
    parameter int NUM_DEST = 12,
    parameter int CODE_W   = $clog2(NUM_DEST + 1)
) (
    input  logic                en_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic [NUM_DEST-1:0] sel_o
);
    for (genvar g = 0; g < NUM_DEST; g++) begin : g_dec
        assign sel_o[g] = en_i && (code_i == CODE_W'(g + 1));
    end
endmodule

// File: rtl/wbu_top.sv
module wbu_top
    import wbu_pkg::*;
#(
    parameter int NUM_DEST = 12,
    localparam int CODE_W  = $clog2(NUM_DEST + 1),
    localparam int SEL_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic [DATA_W-1:0] ftm_i,
    input  logic [CODE_W-1:0] rtm_i,
    input  logic [CODE_W-1:0] rd_sel_i,
    input  logic [SEL_W-1:0]  br_sel_i,
    input  logic              br_want_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              br_taken_o
);
    typedef struct packed {
        logic [DATA_W-1:0]                 p;
        logic [NUM_DEST-1:0][DATA_W-1:0]   regs;
        logic [DATA_W-1:0]                 status;
        logic [DATA_W-1:0]                 rd;
        logic                              br;
    } wb_state_t;

    wb_state_t st_d, st_q;
    logic [DATA_W-1:0]   flags_new;
    logic [NUM_DEST-1:0] dest_we;

    wbu_flag_calc u_flags (
        .res_i   (res_i),
        .carry_i (carry_i),
        .ovf_i   (ovf_i),
        .flags_o (flags_new)
    );

    wbu_dest_decode #(.NUM_DEST(NUM_DEST), .CODE_W(CODE_W)) u_dest (
        .en_i   (!half_i),
        .code_i (rtm_i),
        .sel_o  (dest_we)
    );

    always_comb begin
        st_d = st_q;
        if (!half_i) begin
            // mid-cycle commit
            st_d.p = (st_q.p & ~ftm_i) | (flags_new & ftm_i) | STATUS_ONE;
            for (int i = 0; i < NUM_DEST; i++) begin
                if (dest_we[i]) st_d.regs[i] = res_i;
            end
        end else begin
            // end-of-cycle sampling
            st_d.status = st_q.p;
            st_d.rd     = '0;
            for (int i = 0; i < NUM_DEST; i++) begin
                if (rd_sel_i == CODE_W'(i + 1)) st_d.rd = st_q.regs[i];
            end
            st_d.br = (st_q.p[br_sel_i] == br_want_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.p      <= STATUS_RST;
            st_q.status <= STATUS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o   = st_q.status;
    assign rd_data_o  = st_q.rd;
    assign br_taken_o = st_q.br;
endmodule

// File: rtl/wbu_checker.sv
module wbu_checker #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 4,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_i,
    input logic [DATA_W-1:0] ftm_i,
    input logic [CODE_W-1:0] rd_sel_i,
    input logic [SEL_W-1:0]  br_sel_i,
    input logic              br_want_i,
    input logic [DATA_W-1:0] p_q,
    input logic [DATA_W-1:0] status_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              br_taken_o
);
    p_bit5_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5] && p_q[5]);

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !half_i |=> ((p_q ^ $past(p_q)) & ~$past(ftm_i)) == '0);

    p_late_no_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        half_i |=> $stable(p_q));

    p_out_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !half_i |=> ($stable(status_o) && $stable(rd_data_o) && $stable(br_taken_o)));

    p_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        half_i |=> (br_taken_o == (status_o[$past(br_sel_i)] == $past(br_want_i))));

    p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (half_i && rd_sel_i == '0) |=> (rd_data_o == '0));
endmodule

bind wbu_top wbu_checker #(.DATA_W(wbu_pkg::DATA_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) i_wbu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_i     (half_i),
    .ftm_i      (ftm_i),
    .rd_sel_i   (rd_sel_i),
    .br_sel_i   (br_sel_i),
    .br_want_i  (br_want_i),
    .p_q        (st_q.p),
    .status_o   (status_o),
    .rd_data_o  (rd_data_o),
    .br_taken_o (br_taken_o)
);

// File: tb/test_wbu_top.sv
module test_wbu_top;
    localparam int ND = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_i = 1'b0;
    logic [7:0] res_i = '0;
    logic       carry_i = 1'b0;
    logic       ovf_i = 1'b0;
    logic [7:0] ftm_i = '0;
    logic [3:0] rtm_i = '0;
    logic [3:0] rd_sel_i = '0;
    logic [2:0] br_sel_i = '0;
    logic       br_want_i = 1'b0;
    logic [7:0] status_o, rd_data_o;
    logic       br_taken_o;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_p;
    logic [7:0] exp_r [1:ND];

    always #5 clk = ~clk;

    wbu_top #(.NUM_DEST(ND)) i_wbu_top (
        .clk(clk), .rst_n(rst_n), .half_i(half_i), .res_i(res_i),
        .carry_i(carry_i), .ovf_i(ovf_i), .ftm_i(ftm_i), .rtm_i(rtm_i),
        .rd_sel_i(rd_sel_i), .br_sel_i(br_sel_i), .br_want_i(br_want_i),
        .status_o(status_o), .rd_data_o(rd_data_o), .br_taken_o(br_taken_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flags_of(input logic [7:0] r, input logic c, input logic v);
        return {r[7], v, 1'b1, r[4], r[3], r[2], (r == 8'h00), c};
    endfunction

    // one processor cycle; second-half inputs may differ (R8)
    task automatic cyc(input logic [7:0] r, input logic c, input logic v,
                       input logic [7:0] m, input logic [3:0] d,
                       input logic [3:0] rs, input logic [2:0] bs, input logic bw,
                       input logic late_mess, input string req);
        logic [7:0] s0, d0;
        logic       b0;
        @(negedge clk);
        half_i = 1'b0; res_i = r; carry_i = c; ovf_i = v; ftm_i = m; rtm_i = d;
        rd_sel_i = rs; br_sel_i = bs; br_want_i = bw;
        s0 = status_o; d0 = rd_data_o; b0 = br_taken_o;
        exp_p = (exp_p & ~m) | (flags_of(r, c, v) & m) | 8'h20;
        if (d >= 1 && d <= ND) exp_r[d] = r;
        @(negedge clk);
        chk({req, " R9 status held mid-cycle"}, status_o, s0);
        chk({req, " R9 read held mid-cycle"}, rd_data_o, d0);
        chk({req, " R9 branch held mid-cycle"}, {7'd0, br_taken_o}, {7'd0, b0});
        half_i = 1'b1;
        if (late_mess) begin
            res_i = ~r; carry_i = ~c; ovf_i = ~v; ftm_i = 8'hFF; rtm_i = 4'd1;
        end
        @(negedge clk);
        chk({req, " status"}, status_o, exp_p);
        chk({req, " read"}, rd_data_o, (rs >= 1 && rs <= ND) ? exp_r[rs] : 8'h00);
        chk({req, " branch"}, {7'd0, br_taken_o}, {7'd0, exp_p[bs] == bw});
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h24);
        chk("R1 read", rd_data_o, 8'h00);
        chk("R1 branch", {7'd0, br_taken_o}, 8'h00);
        for (int k = 1; k <= ND; k++) cyc(8'h00, 0, 0, 8'h00, 0, k[3:0], 0, 0, 0, "R1 reg zero");
    endtask

    task automatic t_nz();
        cyc(8'h80, 0, 0, 8'h82, 0, 0, 7, 1, 0, "R2 N set Z clear");
        cyc(8'h00, 0, 0, 8'h82, 0, 0, 1, 1, 0, "R2 Z set N clear");
        cyc(8'h7F, 0, 0, 8'h82, 0, 0, 1, 0, 0, "R2 both clear");
    endtask

    task automatic t_cv();
        cyc(8'h10, 1, 1, 8'h41, 0, 0, 0, 1, 0, "R3 C V set");
        cyc(8'h10, 0, 1, 8'h01, 0, 0, 6, 1, 0, "R3 C only");
        cyc(8'h10, 1, 0, 8'h40, 0, 0, 6, 0, 0, "R3 V only");
    endtask

    task automatic t_mask();
        cyc(8'hFF, 1, 1, 8'h00, 0, 0, 5, 1, 0, "R4 empty mask");
        cyc(8'h00, 0, 0, 8'hDF, 0, 0, 5, 1, 0, "R4 full mask bit5");
        cyc(8'hA5, 1, 0, 8'h18, 0, 0, 0, 0, 0, "R4 partial mask");
    endtask

    task automatic t_bdi();
        cyc(8'h1C, 0, 0, 8'h1C, 0, 0, 4, 1, 0, "R5 B D I set");
        cyc(8'hE3, 0, 0, 8'h1C, 0, 0, 2, 0, 0, "R5 B D I clear");
    endtask

    task automatic t_dest();
        for (int k = 1; k <= ND; k++)
            cyc(8'(k * 17) ^ 8'h5A, 0, 0, 8'h00, k[3:0], k[3:0], 0, 0, 0, "R6 R9 same-cycle read");
        for (int k = 1; k <= ND; k++)
            cyc(8'h00, 0, 0, 8'h00, 0, k[3:0], 0, 0, 0, "R6 readback");
    endtask

    task automatic t_nodest();
        cyc(8'hFF, 0, 0, 8'h00, 0, 4'd1, 0, 0, 0, "R7 code zero");
        cyc(8'hEE, 0, 0, 8'h00, 4'd13, 4'd2, 0, 0, 0, "R7 code 13");
        cyc(8'hDD, 0, 0, 8'h00, 4'd15, 4'd3, 0, 0, 0, "R7 code 15");
        for (int k = 1; k <= ND; k++)
            cyc(8'h00, 0, 0, 8'h00, 0, k[3:0], 0, 0, 0, "R7 readback");
    endtask

    task automatic t_phase();
        cyc(8'h00, 0, 0, 8'h00, 0, 4'd1, 1, 1, 1, "R8 late inputs");
        cyc(8'h42, 1, 0, 8'h03, 4'd2, 4'd1, 0, 1, 1, "R8 late after write");
        cyc(8'h00, 0, 0, 8'h00, 0, 4'd2, 0, 1, 0, "R8 readback");
    endtask

    task automatic t_branch();
        for (int b = 0; b < 8; b++) begin
            cyc(8'h80, 1, 0, 8'hC3, 0, 0, b[2:0], 1, 0, "R10 want one");
            cyc(8'h80, 1, 0, 8'hC3, 0, 0, b[2:0], 0, 0, "R10 want zero");
        end
        cyc(8'h00, 0, 0, 8'h02, 0, 0, 1, 1, 0, "R10 same-cycle Z");
    endtask

    task automatic t_rdsel();
        cyc(8'h00, 0, 0, 8'h00, 0, 4'd0, 0, 0, 0, "R11 select zero");
        cyc(8'h00, 0, 0, 8'h00, 0, 4'd13, 0, 0, 0, "R11 select 13");
        cyc(8'h00, 0, 0, 8'h00, 0, 4'd15, 0, 0, 0, "R11 select 15");
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        exp_p = 8'h24;
        for (int k = 1; k <= ND; k++) exp_r[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nz();
        t_cv();
        t_mask();
        t_bdi();
        t_dest();
        t_nodest();
        t_phase();
        t_branch();
        t_rdsel();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule